// File: doc/BRIEF.md
# I2C Slave Windowed Read Engine

This block is the I2C slave front end for a small block of nonvolatile calibration bytes. It answers a 7-bit slave address and serves reads from a synchronous byte-wide storage array. An internal address counter always points one past the location accessed last. The counter is confined to a seven-entry window, 62h to 68h, and it wraps from 68h back to 62h.

The block supports two kinds of read. In a current-address read, the master sends the slave address with the read bit set, and the block returns bytes starting at the counter. In a random read, a dummy write carries a one-byte register address, which loads the counter. A repeated start with the read bit set follows, and the block returns the byte at that address.

Byte writes after the register address are acknowledged. They move the counter only; no storage is written. SCL and SDA are sampled through two-flop synchronizers. A start condition or a stop condition aborts whatever bit-level phase is in progress.

Top module: `i2c_rd_engine`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0) and the counter holds 62h, so the first current-address read returns the byte stored at 62h.
- R2: The block acknowledges only the slave address formed as {5'b10110, `addr_sel[1:0]`}; bit 0 of the address byte is R/W, with 1 meaning read. For any other address it sends no ACK and does not pull SDA low until the next start condition.
- R3: A read returns the byte at the counter, MSB first. The counter then advances by one, and the block keeps sending consecutive bytes for as long as the master acknowledges each one. The storage port is synchronous: `mem_rdata` reflects `mem_addr` one clock later.
- R4: Advancing from 68h gives 62h, so the counter never leaves the window 62h–68h.
- R5: A random read loads the counter with the register address from the dummy write. The read after the repeated start returns the data at that address and continues from there.
- R6: A register address below 62h or above 68h is clamped to 62h.
- R7: A master NACK followed by a stop ends the read and releases SDA. The next current-address read continues one past the last byte sent.
- R8: Data bytes written after the register address are acknowledged, and each one advances the counter by one.
- R9: `sda_oe` changes only just after a detected falling edge of SCL, never while SCL is high.
- R10: A start or stop at any bit position abandons the current byte. The next complete transaction behaves normally, and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen at the pad |
| sda_in | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain) |
| addr_sel | input | 2 | Select pins forming the low two slave address bits |
| mem_addr | output | 8 | Storage read address (equals the counter) |
| mem_rdata | input | 8 | Storage read data, one clock after the address |

## Verification
A counter that slips or wraps wrongly shows up as the wrong data byte on the very next byte read. A bad wrap is caught at the read that follows 68h. A bad clamp is caught at the first read after a random-read setup. A bit state machine that fails to reset on start or stop shows up at the next transaction as a missing ACK or a shifted byte. A stuck `sda_oe` pulls down a bit the master expects to see high within one SCL period.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  parameter int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_MACK
  } phase_t;

  typedef enum logic [1:0] {
    RK_SLA, RK_REG, RK_DAT
  } rx_kind_t;

  // Out-of-window values fall back to the window base.
  function automatic addr_t win_clamp(input addr_t a, input addr_t lo, input addr_t hi);
    return (a < lo || a > hi) ? lo : a;
  endfunction

  // Successor inside the window, wrapping at the top.
  function automatic addr_t win_next(input addr_t a, input addr_t lo, input addr_t hi);
    return (a >= hi || a < lo) ? lo : a + addr_t'(1);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/win_addr_ctr.sv
module win_addr_ctr
  import i2c_rd_pkg::*;
#(
  parameter addr_t LO = 8'h62,
  parameter addr_t HI = 8'h68
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  addr_t load_val,
  input  logic  step,
  output addr_t addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= LO;
    else if (load_en) addr <= win_clamp(load_val, LO, HI);
    else if (step)    addr <= win_next(addr, LO, HI);
  end
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter logic [4:0] SLA_PREFIX = 5'b10110,
  parameter addr_t      WIN_LO     = 8'h62,
  parameter addr_t      WIN_HI     = 8'h68,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  output addr_t       mem_addr,
  input  logic [7:0]  mem_rdata
);
  localparam int BITS     = 8;
  localparam int CNT_W    = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  phase_t   phase;
  rx_kind_t kind;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] shreg;
  logic rd_mode, mack_ok;
  logic [6:0] own_sla;

  // Named internal events for the checker.
  logic byte_load, ctr_set, wr_step, bus_idle, rx_done;
  addr_t ctr_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign own_sla   = {SLA_PREFIX, addr_sel};
  assign bus_idle  = (phase == PH_IDLE);
  assign rx_done   = (phase == PH_RX) && scl_fall && (bit_cnt == LAST);
  assign ctr_set   = rx_done && (kind == RK_REG);
  assign wr_step   = rx_done && (kind == RK_DAT);
  assign byte_load = scl_fall &&
                     (((phase == PH_ACK) && (kind == RK_SLA) && rd_mode) ||
                      ((phase == PH_MACK) && mack_ok));

  win_addr_ctr #(.LO(WIN_LO), .HI(WIN_HI)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load_en(ctr_set), .load_val(shreg),
    .step(byte_load | wr_step),
    .addr(ctr_addr)
  );

  assign mem_addr = ctr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      kind    <= RK_SLA;
      bit_cnt <= '0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_RX;
      kind    <= RK_SLA;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && bit_cnt != LAST) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + CNT_W'(1);
          end else if (rx_done) begin
            if (kind != RK_SLA || shreg[7:1] == own_sla) begin
              if (kind == RK_SLA) rd_mode <= shreg[0];
              sda_oe <= 1'b1;
              phase  <= PH_ACK;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_ACK: begin
          if (byte_load) begin
            shreg   <= {mem_rdata[6:0], 1'b0};
            sda_oe  <= ~mem_rdata[7];
            bit_cnt <= CNT_W'(1);
            phase   <= PH_TX;
          end else if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            phase   <= PH_RX;
            kind    <= (kind == RK_SLA) ? RK_REG : RK_DAT;
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt == LAST) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              phase   <= PH_MACK;
            end else begin
              sda_oe  <= ~shreg[7];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (byte_load) begin
            shreg   <= {mem_rdata[6:0], 1'b0};
            sda_oe  <= ~mem_rdata[7];
            bit_cnt <= CNT_W'(1);
            phase   <= PH_TX;
          end else if (scl_fall) begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_engine_chk.sv
module i2c_rd_engine_chk
  import i2c_rd_pkg::*;
#(
  parameter addr_t LO = 8'h62,
  parameter addr_t HI = 8'h68
) (
  input logic  clk,
  input logic  rst_n,
  input logic  sda_oe,
  input logic  scl_fall,
  input logic  start_det,
  input logic  stop_det,
  input logic  bus_idle,
  input logic  byte_load,
  input logic  ctr_set,
  input logic [7:0] shreg,
  input addr_t ctr_addr
);
  // R2: an idle or ignoring slave never pulls SDA low
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  // R9: SDA drive moves only right after a detected SCL fall
  a_r9_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> $past(scl_fall));

  // R4: counter stays in its window
  a_r4_ctr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_addr >= LO) && (ctr_addr <= HI));

  // R3: each loaded byte advances the counter by one window step
  a_r3_load_steps: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> ctr_addr == win_next($past(ctr_addr), LO, HI));

  // R6: a register address lands clamped in the counter
  a_r6_set_clamps: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_set |=> ctr_addr == win_clamp($past(shreg), LO, HI));

  // R7: a stop always leaves SDA released
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_rd_engine i2c_rd_engine_chk #(.LO(WIN_LO), .HI(WIN_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .bus_idle(bus_idle),
  .byte_load(byte_load), .ctr_set(ctr_set), .shreg(shreg), .ctr_addr(ctr_addr)
);

// File: tb/i2c_rd_engine_tb.sv
`timescale 1ns/1ps
module i2c_rd_engine_tb;
  localparam logic [4:0] PFX = 5'b10110;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [1:0] sel = 2'b01;
  logic [7:0] mem_addr, mem_rdata;
  wire sda_line = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, scl_hi_moves = 0;
  logic [7:0] exp_ctr = 8'h62;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;

  i2c_rd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_sel(sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mval(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] m_next(input logic [7:0] a);
    return 8'h62 + 8'((int'(a) - 'h62 + 1) % 7);
  endfunction
  function automatic logic [7:0] m_clamp(input logic [7:0] a);
    return (a > 8'h68 || a < 8'h62) ? 8'h62 : a;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mval(mem_addr);

  // R9 monitor: drive must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && m_scl) scl_hi_moves++;
    prev_oe = sda_oe;
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic start_c;
    m_scl = 0; w(Q); m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask
  task automatic stop_c;
    m_scl = 0; w(Q); m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q);
  endtask
  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; w(Q); m_scl = 1; w(Q); s = sda_line; w(Q); m_scl = 0; w(Q);
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask
  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(nack, s);
  endtask

  task automatic read_run(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);
      chk(d, mval(exp_ctr), req);
      exp_ctr = m_next(exp_ctr);
    end
  endtask

  task automatic cur_read(input int n, input string req);
    logic ack;
    start_c; wr_byte({PFX, sel, 1'b1}, ack);
    chk({7'd0, ack}, 8'd1, "R2 read address ACK");
    read_run(n, req);
    stop_c;
  endtask

  task automatic rnd_read(input logic [7:0] ra, input int n, input string req);
    logic ack;
    start_c; wr_byte({PFX, sel, 1'b0}, ack);
    chk({7'd0, ack}, 8'd1, "R2 write address ACK");
    wr_byte(ra, ack);
    chk({7'd0, ack}, 8'd1, "R5 register address ACK");
    exp_ctr = m_clamp(ra);
    start_c; wr_byte({PFX, sel, 1'b1}, ack);
    chk({7'd0, ack}, 8'd1, "R5 repeated-start ACK");
    read_run(n, req);
    stop_c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report;
  end

  initial begin
    logic ack, s;
    logic [7:0] d;
    w(5); rst_n = 1; w(5);
    chk({7'd0, sda_oe}, 8'd0, "R1 SDA released after reset");
    cur_read(1, "R1 first read at 62h");
    cur_read(9, "R3/R4 sequential read across wrap");
    for (int a = 'h62; a <= 'h68; a++) rnd_read(8'(a), 2, "R5 random read");
    rnd_read(8'h10, 1, "R6 clamp low");
    rnd_read(8'hF0, 1, "R6 clamp high");
    rnd_read(8'h67, 3, "R4 wrap after random read");
    cur_read(2, "R7 continue after NACK/stop");
    // R8: write data bytes advance the counter
    start_c; wr_byte({PFX, sel, 1'b0}, ack);
    wr_byte(8'h65, ack); exp_ctr = 8'h65;
    wr_byte(8'hAA, ack); chk({7'd0, ack}, 8'd1, "R8 data byte ACK");
    exp_ctr = m_next(exp_ctr);
    wr_byte(8'h55, ack); chk({7'd0, ack}, 8'd1, "R8 data byte ACK");
    exp_ctr = m_next(exp_ctr);
    stop_c;
    cur_read(1, "R8 read after data writes");
    // R2: wrong select bits are ignored
    start_c; wr_byte({PFX, 2'b10, 1'b1}, ack);
    chk({7'd0, ack}, 8'd0, "R2 mismatched address no ACK");
    rd_byte(1'b1, d);
    chk(d, 8'hFF, "R2 no drive after mismatch");
    stop_c;
    cur_read(1, "R2 counter unchanged after mismatch");
    // R10: stop and start in mid-byte
    start_c; clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); stop_c;
    cur_read(1, "R10 recovery after mid-byte stop");
    start_c; for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    rnd_read(8'h64, 2, "R10 recovery after mid-byte start");
    // R2: other select value
    sel = 2'b10; w(4);
    cur_read(2, "R2 new select value");
    chk(8'(scl_hi_moves), 8'd0, "R9 SDA drive steady while SCL high");
    chk({7'd0, sda_oe}, 8'd0, "R7 SDA released at end");
    report;
  end
endmodule